// File: doc/BRIEF.md
# NAND Bad-Block Scanner

The scanner walks an inclusive range of erase blocks on a NAND device and records, for each block, whether the factory marker in its spare area shows the block as bad. For every block in the range it asks a page reader for a spare-only read of that block's first page. It then takes the spare bytes that come back on a byte stream and writes the block's bad bit and its known bit into an on-chip bitmap.

Software or a sequencer sets the geometry inputs and the requested range, then pulses `start` while `done` is high. The range is made legal before the walk begins. The scanner then issues one read request per block, lowest block first. `done` returns high once the last block has been written.

There are two streaming interfaces. The read request is a valid/ready pair. Once `rd_req_valid` is raised, it and `rd_req_page` hold unchanged until `rd_req_ready` is seen high at a clock edge. On the spare-byte stream the reader is the source and may insert gaps by lowering `sp_valid`. The scanner applies back-pressure by holding `sp_ready` low whenever it is not waiting for spare bytes. A byte moves on a clock edge where both `sp_valid` and `sp_ready` are high. The byte that carries `sp_last` ends the stream for that block.

Top module: `nand_bbt_scanner`

## Requirements
- R1: When `start` is accepted, a first index that is negative or not less than `num_blocks` is replaced by 0.
- R2: When `start` is accepted, a last index equal to -1 or not less than `num_blocks` is replaced by `num_blocks` - 1.
- R3: One read request is made per block, in ascending order from the first index to the last. The page for block k is k × `pages_per_blk`. The request and its page stay stable until `rd_req_ready` is seen.
- R4: When `bus_16` = 1, the block is bad if spare byte 0 ANDed with spare byte 1 differs from 0xFF.
- R5: When `page_2k` = 0 (512-byte pages), the block is bad if spare byte 5 differs from 0xFF.
- R6: When `page_2k` = 1 (2048-byte pages), the block is bad if spare byte 0 differs from 0xFF. Byte 5 plays no part in this case.
- R7: A scanned block that fails none of the checks in R4 to R6 has its `bad_map` bit cleared, even if the bit was set earlier.
- R8: `known_map` bit k becomes 1 when block k is scanned and is otherwise 0 from reset. No bit of either map outside the scanned range changes.
- R9: Spare bytes after the sixth byte of a stream are consumed and ignored. If a stream ends before six bytes, each missing byte counts as 0xFF.
- R10: `start` is ignored while `done` is low. A scan in progress is not disturbed by it.
- R11: If the range after clamping is empty (first > last), no request is made and `done` stays high.
- R12: After reset, `done` = 1, both maps are all zero, and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan. Accepted only while `done` is high |
| first_blk | input | IDX_W (8) | Signed first block index |
| last_blk | input | IDX_W (8) | Signed last block index. -1 selects the final block |
| num_blocks | input | CNT_W (7) | Number of blocks on the device |
| pages_per_blk | input | PPB_W (8) | Pages in one erase block |
| page_2k | input | 1 | 1 = 2048-byte pages, 0 = 512-byte pages |
| bus_16 | input | 1 | 1 = 16-bit device bus |
| rd_req_valid | output | 1 | Spare-only read request valid |
| rd_req_ready | input | 1 | Page reader accepts the request |
| rd_req_page | output | PAGE_W (14) | Page to read |
| sp_valid | input | 1 | Spare byte valid |
| sp_ready | output | 1 | Scanner accepts a spare byte |
| sp_data | input | 8 | Spare byte |
| sp_last | input | 1 | Final spare byte of this read |
| bad_map | output | MAX_BLOCKS (64) | Bad bit per block |
| known_map | output | MAX_BLOCKS (64) | Block has been scanned |
| done | output | 1 | Idle; no scan in progress |

## Verification
A wrong block counter or page register shows up on `rd_req_page` at the next request, one handshake after the error. A corrupted range register shows up as a missing or extra request, or as `done` rising too early or too late. Errors in the byte capture or in the verdict stay hidden until the block's update cycle. They then appear as a wrong `bad_map` bit one cycle after the last spare byte. A write to the wrong index appears in the same cycle as a change to `known_map` outside the scanned range.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REQ     = 2'd1,
    ST_COLLECT = 2'd2,
    ST_UPDATE  = 2'd3
  } nbs_state_e;

  // Spare bytes examined per block; the marker rules use bytes 0, 1 and 5.
  localparam int SPARE_BYTES = 6;
  localparam logic [7:0] ERASED = 8'hFF;
endpackage

// File: rtl/nbs_range_clamp.sv
module nbs_range_clamp #(
  parameter int BLK_W = 6,
  parameter int IDX_W = BLK_W + 2,
  parameter int CNT_W = BLK_W + 1
) (
  input  logic signed [IDX_W-1:0] first_i,
  input  logic signed [IDX_W-1:0] last_i,
  input  logic        [CNT_W-1:0] count_i,
  output logic        [BLK_W-1:0] lo_o,
  output logic signed [IDX_W-1:0] hi_o,
  output logic                    empty_o
);
  logic signed [IDX_W-1:0] count_s;
  logic signed [IDX_W-1:0] lo_s;
  logic signed [IDX_W-1:0] minus_one;

  assign minus_one = '1;
  assign count_s   = $signed({{(IDX_W-CNT_W){1'b0}}, count_i});

  always_comb begin
    if (first_i < 0 || first_i >= count_s) lo_s = '0;
    else                                   lo_s = first_i;
    if (last_i == minus_one || last_i >= count_s) hi_o = count_s - 1;
    else                                          hi_o = last_i;
  end

  assign empty_o = (lo_s > hi_o);
  assign lo_o    = lo_s[BLK_W-1:0];
endmodule

// File: rtl/nbs_spare_capture.sv
module nbs_spare_capture #(
  parameter int NBYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic                   beat_i,
  input  logic [7:0]             data_i,
  output logic [NBYTES-1:0][7:0] bytes_o
);
  localparam int CW = $clog2(NBYTES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clear_i)                   cnt_q <= '0;
    else if (beat_i && cnt_q != CW'(NBYTES)) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             bytes_o[i] <= 8'hFF;
      else if (clear_i)                       bytes_o[i] <= 8'hFF;
      else if (beat_i && cnt_q == CW'(i))     bytes_o[i] <= data_i;
    end
  end
endmodule

// File: rtl/nbs_verdict.sv
module nbs_verdict #(
  parameter int NBYTES = 6
) (
  input  logic [NBYTES-1:0][7:0] bytes_i,
  input  logic                   wide_bus_i,
  input  logic                   big_page_i,
  output logic                   bad_o
);
  logic bus_fail;
  logic small_fail;
  logic big_fail;

  assign bus_fail   = wide_bus_i  && ((bytes_i[0] & bytes_i[1]) != 8'hFF);
  assign small_fail = !big_page_i && (bytes_i[5] != 8'hFF);
  assign big_fail   = big_page_i  && (bytes_i[0] != 8'hFF);
  assign bad_o      = bus_fail || small_fail || big_fail;
endmodule

// File: rtl/nbs_bitmap.sv
module nbs_bitmap #(
  parameter int N     = 64,
  parameter int BLK_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [BLK_W-1:0] wr_idx_i,
  input  logic             wr_bad_i,
  output logic [N-1:0]     bad_o,
  output logic [N-1:0]     known_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == BLK_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bad_o[i]   <= 1'b0;
        known_o[i] <= 1'b0;
      end else if (hit) begin
        bad_o[i]   <= wr_bad_i;
        known_o[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_bbt_scanner.sv
module nand_bbt_scanner
  import nbs_pkg::*;
#(
  parameter int MAX_BLOCKS = 64,
  parameter int PPB_W      = 8,
  localparam int BLK_W  = $clog2(MAX_BLOCKS),
  localparam int CNT_W  = BLK_W + 1,
  localparam int IDX_W  = BLK_W + 2,
  localparam int PAGE_W = BLK_W + PPB_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [IDX_W-1:0] first_blk,
  input  logic signed [IDX_W-1:0] last_blk,
  input  logic [CNT_W-1:0]        num_blocks,
  input  logic [PPB_W-1:0]        pages_per_blk,
  input  logic                    page_2k,
  input  logic                    bus_16,
  output logic                    rd_req_valid,
  input  logic                    rd_req_ready,
  output logic [PAGE_W-1:0]       rd_req_page,
  input  logic                    sp_valid,
  output logic                    sp_ready,
  input  logic [7:0]              sp_data,
  input  logic                    sp_last,
  output logic [MAX_BLOCKS-1:0]   bad_map,
  output logic [MAX_BLOCKS-1:0]   known_map,
  output logic                    done
);
  nbs_state_e              state_q;
  logic [BLK_W-1:0]        cur_q;
  logic signed [IDX_W-1:0] hi_q;
  logic [PAGE_W-1:0]       page_q;
  logic [PPB_W-1:0]        ppb_q;
  logic                    big_q;
  logic                    wide_q;

  logic [BLK_W-1:0]        lo_c;
  logic signed [IDX_W-1:0] hi_c;
  logic                    empty_c;
  logic                    go;
  logic                    beat;
  logic                    at_end;
  logic                    verdict;
  logic [SPARE_BYTES-1:0][7:0] spare;

  nbs_range_clamp #(.BLK_W(BLK_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_clamp (
    .first_i (first_blk),
    .last_i  (last_blk),
    .count_i (num_blocks),
    .lo_o    (lo_c),
    .hi_o    (hi_c),
    .empty_o (empty_c)
  );

  assign go       = start && (state_q == ST_IDLE) && !empty_c;
  assign sp_ready = (state_q == ST_COLLECT);
  assign beat     = sp_valid && sp_ready;
  assign at_end   = ($signed({2'b00, cur_q}) == hi_q);

  nbs_spare_capture #(.NBYTES(SPARE_BYTES)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (state_q == ST_REQ),
    .beat_i  (beat),
    .data_i  (sp_data),
    .bytes_o (spare)
  );

  nbs_verdict #(.NBYTES(SPARE_BYTES)) u_verdict (
    .bytes_i    (spare),
    .wide_bus_i (wide_q),
    .big_page_i (big_q),
    .bad_o      (verdict)
  );

  nbs_bitmap #(.N(MAX_BLOCKS), .BLK_W(BLK_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (state_q == ST_UPDATE),
    .wr_idx_i (cur_q),
    .wr_bad_i (verdict),
    .bad_o    (bad_map),
    .known_o  (known_map)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      hi_q    <= '0;
      page_q  <= '0;
      ppb_q   <= '0;
      big_q   <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_REQ;
          cur_q   <= lo_c;
          hi_q    <= hi_c;
          page_q  <= PAGE_W'(lo_c) * PAGE_W'(pages_per_blk);
          ppb_q   <= pages_per_blk;
          big_q   <= page_2k;
          wide_q  <= bus_16;
        end
        ST_REQ: if (rd_req_ready) state_q <= ST_COLLECT;
        ST_COLLECT: if (beat && sp_last) state_q <= ST_UPDATE;
        ST_UPDATE: begin
          if (at_end) begin
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_REQ;
            cur_q   <= cur_q + 1'b1;
            page_q  <= page_q + PAGE_W'(ppb_q);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (state_q == ST_REQ);
  assign rd_req_page  = page_q;
  assign done         = (state_q == ST_IDLE);
endmodule

// File: rtl/nbs_scan_checker.sv
module nbs_scan_checker #(
  parameter int MAX_BLOCKS = 64,
  parameter int PAGE_W     = 14
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rd_req_valid,
  input logic                  rd_req_ready,
  input logic [PAGE_W-1:0]     rd_req_page,
  input logic                  sp_ready,
  input logic [MAX_BLOCKS-1:0] bad_map,
  input logic [MAX_BLOCKS-1:0] known_map,
  input logic                  done
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_page));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req_valid && !sp_ready);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sp_ready |-> !rd_req_valid);

  assert_known_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (known_map & $past(known_map)) == $past(known_map));

  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones((known_map ^ $past(known_map)) | (bad_map ^ $past(bad_map))) <= 1);

  assert_bad_known_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_map & ~known_map) == '0);
endmodule

bind nand_bbt_scanner nbs_scan_checker #(
  .MAX_BLOCKS(MAX_BLOCKS),
  .PAGE_W(PAGE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_page  (rd_req_page),
  .sp_ready     (sp_ready),
  .bad_map      (bad_map),
  .known_map    (known_map),
  .done         (done)
);

// File: tb/nand_bbt_scanner_tb.sv
module nand_bbt_scanner_tb;
  localparam int MAXB = 64;
  localparam int BW   = 6;
  localparam int IW   = 8;
  localparam int CW   = 7;
  localparam int PW   = 8;
  localparam int GW   = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [IW-1:0] first_blk = '0, last_blk = '0;
  logic [CW-1:0] num_blocks = '0;
  logic [PW-1:0] pages_per_blk = '0;
  logic page_2k = 1'b0, bus_16 = 1'b0;
  logic rd_req_valid, rd_req_ready;
  logic [GW-1:0] rd_req_page;
  logic sp_valid, sp_ready, sp_last;
  logic [7:0] sp_data;
  logic [MAXB-1:0] bad_map, known_map;
  logic done;

  always #4 clk = ~clk;

  nand_bbt_scanner #(.MAX_BLOCKS(MAXB), .PPB_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .first_blk(first_blk), .last_blk(last_blk), .num_blocks(num_blocks),
    .pages_per_blk(pages_per_blk), .page_2k(page_2k), .bus_16(bus_16),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_page(rd_req_page),
    .sp_valid(sp_valid), .sp_ready(sp_ready), .sp_data(sp_data), .sp_last(sp_last),
    .bad_map(bad_map), .known_map(known_map), .done(done)
  );

  logic [7:0] spare_mem [MAXB][8];
  int spare_len [MAXB];
  int page_q[$];
  int blk_q[$];
  logic [MAXB-1:0] exp_bad = '0, exp_known = '0;
  int n_tests = 0, n_fail = 0;
  bit stall_tog = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [MAXB-1:0] act, input logic [MAXB-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit model_bad(input int b, input bit wide, input bit big);
    logic [7:0] by [6];
    for (int k = 0; k < 6; k++) by[k] = (k < spare_len[b]) ? spare_mem[b][k] : 8'hFF;
    return (wide && ((by[0] & by[1]) != 8'hFF)) || (!big && by[5] != 8'hFF) ||
           (big && by[0] != 8'hFF);
  endfunction

  // Page-reader model and monitor: pops expected requests, serves spare bytes.
  initial begin
    int blk;
    rd_req_ready = 1'b0; sp_valid = 1'b0; sp_last = 1'b0; sp_data = 8'h00;
    forever begin
      @(negedge clk); #1;
      if (rd_req_valid) begin
        if (page_q.size() == 0) begin
          check(1'b0, "R10/R11", "unexpected request page", MAXB'(rd_req_page), '0);
          blk = 0;
        end else begin
          int ep;
          ep = page_q.pop_front();
          blk = blk_q.pop_front();
          check(int'(rd_req_page) == ep, "R3", "request page", MAXB'(rd_req_page), MAXB'(ep));
        end
        if (stall_tog) repeat (2) @(negedge clk);
        stall_tog = ~stall_tog;
        rd_req_ready = 1'b1;
        @(negedge clk);
        rd_req_ready = 1'b0;
        for (int k = 0; k < spare_len[blk]; k++) begin
          sp_valid = 1'b1;
          sp_data  = spare_mem[blk][k];
          sp_last  = (k == spare_len[blk] - 1);
          #1;
          while (!sp_ready) begin @(negedge clk); #1; end
          @(negedge clk);
        end
        sp_valid = 1'b0; sp_last = 1'b0;
      end
    end
  end

  task automatic run_scan(input int first, input int last, input int num, input int ppb,
                          input bit big, input bit wide, input bit poke_busy, input string tag);
    int lo, hi;
    lo = (first < 0 || first >= num) ? 0 : first;
    hi = (last == -1 || last >= num) ? num - 1 : last;
    for (int i = lo; i <= hi; i++) begin
      page_q.push_back(i * ppb);
      blk_q.push_back(i);
      exp_bad[i]   = model_bad(i, wide, big);
      exp_known[i] = 1'b1;
    end
    @(negedge clk);
    first_blk = IW'(first); last_blk = IW'(last); num_blocks = CW'(num);
    pages_per_blk = PW'(ppb); page_2k = big; bus_16 = wide;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (lo > hi) begin
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        check(done === 1'b1, "R11", {tag, " done held"}, MAXB'(done), 1);
      end
    end else begin
      if (poke_busy) begin
        @(negedge clk);
        check(done === 1'b0, "R10", {tag, " busy"}, MAXB'(done), 0);
        first_blk = 8'sd40; last_blk = 8'sd50; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      while (done !== 1'b1) @(negedge clk);
    end
    check(page_q.size() == 0, "R3", {tag, " requests left"}, MAXB'(page_q.size()), 0);
    check(bad_map === exp_bad, "R8", {tag, " bad_map"}, bad_map, exp_bad);
    check(known_map === exp_known, "R8", {tag, " known_map"}, known_map, exp_known);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog expired: actual hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int b = 0; b < MAXB; b++) begin
      spare_len[b] = 6;
      for (int k = 0; k < 8; k++) spare_mem[b][k] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(done === 1'b1, "R12", "done after reset", MAXB'(done), 1);
    check(bad_map === '0, "R12", "bad_map after reset", bad_map, '0);
    check(known_map === '0, "R12", "known_map after reset", known_map, '0);
    check(rd_req_valid === 1'b0, "R12", "no request after reset", MAXB'(rd_req_valid), 0);

    // R5: 512-byte page, 8-bit bus, byte 5 decides; byte 0 ignored
    spare_mem[2][5] = 8'h00;
    spare_mem[1][0] = 8'h00;
    run_scan(0, 3, 64, 32, 1'b0, 1'b0, 1'b0, "t512");
    check(bad_map[2] === 1'b1, "R5", "byte5 marked", MAXB'(bad_map[2]), 1);
    check(bad_map[1] === 1'b0, "R5", "byte0 ignored", MAXB'(bad_map[1]), 0);

    // R1 negative first, R6 2048-byte page, R7 good block clears bit
    run_scan(-3, 2, 16, 64, 1'b1, 1'b0, 1'b0, "t2k");
    check(bad_map[1] === 1'b1, "R6", "byte0 marked", MAXB'(bad_map[1]), 1);
    check(bad_map[2] === 1'b0, "R7", "bit cleared", MAXB'(bad_map[2]), 0);

    // R2 last = -1, R4 wide bus, R9 long and short streams
    spare_mem[13][1] = 8'h7F;
    spare_mem[12][5] = 8'h00;
    spare_len[14] = 8; spare_mem[14][6] = 8'h00; spare_mem[14][7] = 8'h00;
    spare_len[15] = 2;
    run_scan(12, -1, 16, 4, 1'b1, 1'b1, 1'b0, "tw16");
    check(bad_map[13] === 1'b1, "R4", "byte0&byte1", MAXB'(bad_map[13]), 1);
    check(bad_map[12] === 1'b0, "R6", "byte5 ignored on 2k", MAXB'(bad_map[12]), 0);
    check(bad_map[14] === 1'b0, "R9", "extra bytes ignored", MAXB'(bad_map[14]), 0);
    check(bad_map[15] === 1'b0 && known_map[15] === 1'b1, "R9", "short stream",
          MAXB'({known_map[15], bad_map[15]}), 2);
    check(known_map[11] === 1'b0, "R8", "outside range unknown", MAXB'(known_map[11]), 0);

    // R1 first too large, R2 last too large, large page stride
    run_scan(20, 100, 16, 255, 1'b0, 1'b1, 1'b0, "tclamp");
    check(bad_map[12] === 1'b1, "R5", "byte5 on 512", MAXB'(bad_map[12]), 1);

    // R11 empty ranges
    run_scan(9, 4, 64, 8, 1'b0, 1'b0, 1'b0, "tempty");
    run_scan(0, -1, 0, 8, 1'b0, 1'b0, 1'b0, "tzero");

    // R10 start while busy ignored
    run_scan(30, 33, 64, 8, 1'b0, 1'b0, 1'b1, "tbusy");
    check(known_map[40] === 1'b0, "R10", "second range untouched", MAXB'(known_map[40]), 0);

    // Whole device, final block bad
    spare_mem[63][0] = 8'h00;
    run_scan(0, 63, 64, 1, 1'b1, 1'b0, 1'b0, "tfull");
    check(bad_map[63] === 1'b1, "R6", "last block", MAXB'(bad_map[63]), 1);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule